// File: doc/BRIEF.md
# Multi-slot SD host register wrapper

This block sits between a 32-bit register port and a set of SD host slot controllers (two by default). It decodes a 4 KiB address window. The lowest 256-byte page holds a bank of global 32-bit words. Each slot gets its own 256-byte page directly above the global page, and accesses there are passed through to that slot's register port.

A few fixed global offsets are live windows onto each slot's capability and maximum-current registers. Those registers are kept inside the wrapper and are driven out to the slots. Each slot's interrupt level is sampled on the clock and mirrored into a status word. A single interrupt output follows the level of whichever slot changed last. It is not an OR of all the slots.

A request is taken in any cycle where `req_valid` is high. `req_ready` is always high. Read data comes back on the next cycle with `rsp_valid`. An access that cannot be served (outside the mapped pages, or not word aligned) gives a one-cycle `err_pulse`.

Top module: `sdhost_wrap`

## Requirements
- R1: After reset the global word at offset 0x000 reads 0x00030000 and the word at 0x004 reads 0x00000005. All other global words read zero, including 0x008, 0x0EC, 0x0F0 and the status word 0x0FC. `irq_out` is low, each `slot_cap` lane holds CAP_RST and each `slot_maxcur` lane holds MC_RST.
- R2: A write to a global offset in 0x000..0x0F8 that is not an alias stores the full 32-bit word. A later read of that offset returns it, one cycle after the request, with `rsp_valid` high.
- R3: For slot i, offset 0x10+0x10*i is that slot's capability register and 0x18+0x10*i is its maximum-current register (0x010/0x018 for slot 0, 0x020/0x028 for slot 1). A write to one of these offsets shows on the matching 32-bit lane of `slot_cap` or `slot_maxcur` at the clock edge that takes the write, and leaves the other lanes unchanged. A read returns the current register value.
- R4: An aligned access to offset (i+1)*0x100 + k raises bit i of `fwd_sel` in the same cycle, with `fwd_addr` = k and `fwd_write`/`fwd_wdata` copied from the request. A read returns the selected slot's lane of `fwd_rdata`, one cycle later.
- R5: An access at or above (NSLOT+1)*0x100 selects no slot and changes no state. A read of it returns zero. Either kind of access raises `err_pulse` for the one cycle in which the response would appear.
- R6: An access whose address bits [1:0] are not zero is rejected in the same way as R5. It forwards nothing, stores nothing and reads back zero.
- R7: When slot n's level goes from low to high, bit n of the status word at 0x0FC is set and `irq_out` goes high after one clock edge.
- R8: When slot n's level goes from high to low, bit n of the status word is cleared and `irq_out` goes low after one clock edge, even if another slot's bit is still set.
- R9: While no slot level changes, `irq_out` and the status word keep their values.
- R10: If several slot levels change at the same edge, `irq_out` takes the new level of the highest-numbered slot among them.
- R11: The status word at 0x0FC is read-only, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Always high; every request is taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle flag for a rejected access |
| fwd_sel | output | NSLOT | One-hot slot select for a pass-through access |
| fwd_write | output | 1 | Write strobe qualifier for the slot port |
| fwd_addr | output | 8 | Offset within the slot page |
| fwd_wdata | output | 32 | Write data for the slot port |
| fwd_rdata | input | 32*NSLOT | Combinational read data from each slot |
| slot_irq | input | NSLOT | Interrupt level from each slot |
| irq_out | output | 1 | Combined interrupt output |
| slot_cap | output | 32*NSLOT | Capability register of each slot |
| slot_maxcur | output | 32*NSLOT | Maximum-current register of each slot |

## Verification
The most likely internal fault is a wrong decode: a word routed to the wrong region or to the wrong slot. It shows on the very next read as wrong data. It shows in the request cycle itself as a wrong `fwd_sel` or a wrong `slot_cap` lane.

A corrupted level history in the interrupt tracker shows on `irq_out` one edge after the next slot level change. It also shows as a missing or extra toggle while levels are held. The simultaneous-change cases tell a "last changed slot" policy apart from an OR of the slots within two edges.

// File: rtl/sdhw_pkg.sv
package sdhw_pkg;

  typedef enum logic [1:0] {
    RG_GLOBAL = 2'd0,
    RG_SLOT   = 2'd1,
    RG_BAD    = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    AL_NONE = 2'd0,
    AL_CAP  = 2'd1,
    AL_MC   = 2'd2
  } alias_e;

  localparam logic [31:0] ID_WORD_RST   = 32'h0003_0000;
  localparam logic [31:0] TIMER_WD_RST  = 32'h0000_0005;
  localparam int          PAGE_BYTES    = 256;
  localparam int          GWORDS        = PAGE_BYTES / 4;
  localparam int          STAT_WORD     = GWORDS - 1;

  function automatic logic [31:0] glb_reset_value(input int w);
    case (w)
      0:       return ID_WORD_RST;
      1:       return TIMER_WD_RST;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/sdhw_decode.sv
module sdhw_decode
  import sdhw_pkg::*;
#(
  parameter int NSLOT = 2,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [11:0]   addr,
  output logic          misal,
  output region_e       region,
  output logic [SW-1:0] slot_idx,
  output alias_e        alias_kind,
  output logic [SW-1:0] alias_slot
);

  logic [3:0] page;
  logic [7:0] off;

  assign page  = addr[11:8];
  assign off   = {addr[7:2], 2'b00};
  assign misal = |addr[1:0];

  always_comb begin
    region   = RG_BAD;
    slot_idx = '0;
    if (page == 4'd0) begin
      region = RG_GLOBAL;
    end else if (int'(page) <= NSLOT) begin
      region   = RG_SLOT;
      slot_idx = SW'(page - 4'd1);
    end
  end

  always_comb begin
    alias_kind = AL_NONE;
    alias_slot = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (off == 8'(16 + 16 * i)) begin
        alias_kind = AL_CAP;
        alias_slot = SW'(i);
      end else if (off == 8'(24 + 16 * i)) begin
        alias_kind = AL_MC;
        alias_slot = SW'(i);
      end
    end
  end

endmodule

// File: rtl/sdhw_regbank.sv
module sdhw_regbank
  import sdhw_pkg::*;
#(
  parameter int          NSLOT   = 2,
  parameter logic [31:0] CAP_RST = 32'h01E8_0080,
  parameter logic [31:0] MC_RST  = 32'h0000_0000,
  localparam int WW = $clog2(GWORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WW-1:0]         wr_word,
  input  logic [31:0]           wdata,
  input  logic [NSLOT-1:0]      cap_we,
  input  logic [NSLOT-1:0]      mc_we,
  input  logic [WW-1:0]         rd_word,
  output logic [31:0]           rd_data,
  output logic [NSLOT*32-1:0]   cap_o,
  output logic [NSLOT*32-1:0]   mc_o
);

  logic [31:0] mem_q [GWORDS];
  logic [31:0] mem_n [GWORDS];
  logic [31:0] cap_q [NSLOT];
  logic [31:0] cap_n [NSLOT];
  logic [31:0] mc_q  [NSLOT];
  logic [31:0] mc_n  [NSLOT];

  always_comb begin
    mem_n = mem_q;
    if (wr_en) mem_n[wr_word] = wdata;
    for (int i = 0; i < NSLOT; i++) begin
      cap_n[i] = cap_we[i] ? wdata : cap_q[i];
      mc_n[i]  = mc_we[i]  ? wdata : mc_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < GWORDS; w++) mem_q[w] <= glb_reset_value(w);
      for (int i = 0; i < NSLOT; i++) begin
        cap_q[i] <= CAP_RST;
        mc_q[i]  <= MC_RST;
      end
    end else begin
      mem_q <= mem_n;
      cap_q <= cap_n;
      mc_q  <= mc_n;
    end
  end

  assign rd_data = mem_q[rd_word];

  for (genvar g = 0; g < NSLOT; g++) begin : g_lane
    assign cap_o[g*32 +: 32] = cap_q[g];
    assign mc_o[g*32 +: 32]  = mc_q[g];

    // R3: alias write lands at the edge that takes it
    p_cap_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_we[g] |=> (cap_o[g*32 +: 32] == $past(wdata)));
    p_mc_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mc_we[g] |=> (mc_o[g*32 +: 32] == $past(wdata)));
  end

endmodule

// File: rtl/sdhw_irq.sv
module sdhw_irq #(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] lvl_i,
  output logic [NSLOT-1:0] status_o,
  output logic             irq_o
);

  logic [NSLOT-1:0] lvl_q;
  logic [NSLOT-1:0] chg;
  logic             irq_q;
  logic             irq_n;

  assign chg = lvl_i ^ lvl_q;

  always_comb begin
    irq_n = irq_q;
    for (int i = 0; i < NSLOT; i++) begin
      if (chg[i]) irq_n = lvl_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      irq_q <= irq_n;
    end
  end

  assign status_o = lvl_q;
  assign irq_o    = irq_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_chk
    // R7: a lone rise sets its bit and the output
    p_rise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((chg == (NSLOT'(1) << g)) && lvl_i[g]) |=> (status_o[g] && irq_o));
    // R8: a lone fall clears its bit and the output
    p_fall_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((chg == (NSLOT'(1) << g)) && !lvl_i[g]) |=> (!status_o[g] && !irq_o));
  end

  // R9: held levels leave the output alone
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg == '0) |=> ($stable(irq_o) && $stable(status_o)));

endmodule

// File: rtl/sdhost_wrap.sv
module sdhost_wrap
  import sdhw_pkg::*;
#(
  parameter int          NSLOT   = 2,
  parameter logic [31:0] CAP_RST = 32'h01E8_0080,
  parameter logic [31:0] MC_RST  = 32'h0000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [11:0]         req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  output logic                err_pulse,
  output logic [NSLOT-1:0]    fwd_sel,
  output logic                fwd_write,
  output logic [7:0]          fwd_addr,
  output logic [31:0]         fwd_wdata,
  input  logic [NSLOT*32-1:0] fwd_rdata,
  input  logic [NSLOT-1:0]    slot_irq,
  output logic                irq_out,
  output logic [NSLOT*32-1:0] slot_cap,
  output logic [NSLOT*32-1:0] slot_maxcur
);

  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int WW = $clog2(GWORDS);

  logic          misal;
  region_e       region;
  logic [SW-1:0] slot_idx;
  alias_e        alias_kind;
  logic [SW-1:0] alias_slot;
  logic [WW-1:0] gword;
  logic          bad;
  logic          is_stat;
  logic          glb_plain;
  logic          glb_wr;
  logic [NSLOT-1:0] cap_we;
  logic [NSLOT-1:0] mc_we;
  logic [31:0]   bank_rd;
  logic [NSLOT-1:0] status;
  logic [31:0]   rd_mux;
  logic          rsp_valid_n, err_n;
  logic [31:0]   rdata_n;
  logic          rsp_valid_q, err_q;
  logic [31:0]   rdata_q;

  sdhw_decode #(.NSLOT(NSLOT)) u_dec (
    .addr       (req_addr),
    .misal      (misal),
    .region     (region),
    .slot_idx   (slot_idx),
    .alias_kind (alias_kind),
    .alias_slot (alias_slot)
  );

  assign gword     = req_addr[WW+1:2];
  assign bad       = misal || (region == RG_BAD);
  assign is_stat   = (int'(gword) == STAT_WORD);
  assign glb_plain = (region == RG_GLOBAL) && !misal && (alias_kind == AL_NONE);
  assign glb_wr    = req_valid && req_write && glb_plain && !is_stat;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      cap_we[i]  = req_valid && req_write && !misal && (region == RG_GLOBAL) &&
                   (alias_kind == AL_CAP) && (alias_slot == SW'(i));
      mc_we[i]   = req_valid && req_write && !misal && (region == RG_GLOBAL) &&
                   (alias_kind == AL_MC) && (alias_slot == SW'(i));
      fwd_sel[i] = req_valid && !misal && (region == RG_SLOT) &&
                   (slot_idx == SW'(i));
    end
  end

  sdhw_regbank #(.NSLOT(NSLOT), .CAP_RST(CAP_RST), .MC_RST(MC_RST)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (glb_wr),
    .wr_word (gword),
    .wdata   (req_wdata),
    .cap_we  (cap_we),
    .mc_we   (mc_we),
    .rd_word (gword),
    .rd_data (bank_rd),
    .cap_o   (slot_cap),
    .mc_o    (slot_maxcur)
  );

  sdhw_irq #(.NSLOT(NSLOT)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_i    (slot_irq),
    .status_o (status),
    .irq_o    (irq_out)
  );

  always_comb begin
    rd_mux = 32'h0;
    if (region == RG_SLOT) begin
      rd_mux = fwd_rdata[slot_idx*32 +: 32];
    end else if (alias_kind == AL_CAP) begin
      rd_mux = slot_cap[alias_slot*32 +: 32];
    end else if (alias_kind == AL_MC) begin
      rd_mux = slot_maxcur[alias_slot*32 +: 32];
    end else if (is_stat) begin
      rd_mux = 32'(status);
    end else begin
      rd_mux = bank_rd;
    end
  end

  always_comb begin
    rsp_valid_n = req_valid && !req_write;
    rdata_n     = (rsp_valid_n && !bad) ? rd_mux : 32'h0;
    err_n       = req_valid && bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= 32'h0;
      err_q       <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_n;
      rdata_q     <= rdata_n;
      err_q       <= err_n;
    end
  end

  assign req_ready = 1'b1;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rdata_q;
  assign err_pulse = err_q;
  assign fwd_write = req_write;
  assign fwd_addr  = req_addr[7:0];
  assign fwd_wdata = req_wdata;

  // R4: at most one slot selected, only for a live aligned request
  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fwd_sel));
  p_sel_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|fwd_sel) |-> (req_valid && !(|req_addr[1:0])));
  // R5: a rejected access returns zero data
  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (rsp_rdata == 32'h0));
  // R6: a misaligned access forwards nothing
  p_misal_nofwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (|req_addr[1:0])) |-> (fwd_sel == '0));

endmodule

// File: tb/sim_sdhost_wrap.sv
`timescale 1ns/1ps
module sim_sdhost_wrap;

  localparam int          NS   = 2;
  localparam logic [31:0] CAPR = 32'h01E8_0080;
  localparam logic [31:0] MCR  = 32'h0000_0000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic              req_ready;
  logic [11:0]       req_addr;
  logic [31:0]       req_wdata;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              err_pulse;
  logic [NS-1:0]     fwd_sel;
  logic              fwd_write;
  logic [7:0]        fwd_addr;
  logic [31:0]       fwd_wdata;
  logic [NS*32-1:0]  fwd_rdata;
  logic [NS-1:0]     slot_irq;
  logic              irq_out;
  logic [NS*32-1:0]  slot_cap, slot_maxcur;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sdhost_wrap #(.NSLOT(NS), .CAP_RST(CAPR), .MC_RST(MCR)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_pulse(err_pulse),
    .fwd_sel(fwd_sel), .fwd_write(fwd_write), .fwd_addr(fwd_addr),
    .fwd_wdata(fwd_wdata), .fwd_rdata(fwd_rdata), .slot_irq(slot_irq),
    .irq_out(irq_out), .slot_cap(slot_cap), .slot_maxcur(slot_maxcur)
  );

  // slot model: read data encodes slot number and offset
  for (genvar g = 0; g < NS; g++) begin : g_slot
    assign fwd_rdata[g*32 +: 32] = 32'hC0DE_0000 | (32'(g) << 8) | 32'(fwd_addr);
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic v,
                        output logic e, output logic [NS-1:0] s, output logic [7:0] fa);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 s = fwd_sel; fa = fwd_addr;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid; e = err_pulse;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] wd, output logic e,
                        output logic [NS-1:0] s, output logic fw, output logic [31:0] fd);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = wd;
    #1 s = fwd_sel; fw = fwd_write; fd = fwd_wdata;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    e = err_pulse;
  endtask

  function automatic logic [31:0] lane(input logic [NS*32-1:0] bus, input int i);
    return bus[i*32 +: 32];
  endfunction

  logic [31:0] d, fd;
  logic v, e, fw;
  logic [NS-1:0] s;
  logic [7:0] fa;

  task automatic t_reset();
    bus_rd(12'h000, d, v, e, s, fa); chk("R1 word 0x000", d, 32'h0003_0000);
    chk("R1 rsp_valid", 32'(v), 32'd1);
    bus_rd(12'h004, d, v, e, s, fa); chk("R1 word 0x004", d, 32'h0000_0005);
    bus_rd(12'h008, d, v, e, s, fa); chk("R1 word 0x008", d, 32'h0);
    bus_rd(12'h0EC, d, v, e, s, fa); chk("R1 word 0x0EC", d, 32'h0);
    bus_rd(12'h0F0, d, v, e, s, fa); chk("R1 word 0x0F0", d, 32'h0);
    bus_rd(12'h0FC, d, v, e, s, fa); chk("R1 status", d, 32'h0);
    chk("R1 irq_out", 32'(irq_out), 32'd0);
    chk("R1 cap0", lane(slot_cap, 0), CAPR);
    chk("R1 cap1", lane(slot_cap, 1), CAPR);
    chk("R1 maxcur1", lane(slot_maxcur, 1), MCR);
  endtask

  task automatic t_storage();
    bus_wr(12'h008, 32'hA1B2_C3D4, e, s, fw, fd);
    bus_wr(12'h040, 32'hDEAD_BEEF, e, s, fw, fd);
    bus_wr(12'h0EC, 32'h0000_0001, e, s, fw, fd);
    bus_rd(12'h008, d, v, e, s, fa); chk("R2 word 0x008", d, 32'hA1B2_C3D4);
    chk("R2 rsp_valid", 32'(v), 32'd1);
    bus_rd(12'h040, d, v, e, s, fa); chk("R2 word 0x040", d, 32'hDEAD_BEEF);
    bus_rd(12'h0EC, d, v, e, s, fa); chk("R2 word 0x0EC", d, 32'h1);
    bus_rd(12'h004, d, v, e, s, fa); chk("R2 neighbour 0x004", d, 32'h5);
  endtask

  task automatic t_alias();
    bus_wr(12'h010, 32'h1111_1111, e, s, fw, fd);
    chk("R3 cap0 after write", lane(slot_cap, 0), 32'h1111_1111);
    chk("R3 cap1 untouched", lane(slot_cap, 1), CAPR);
    bus_wr(12'h018, 32'h2222_2222, e, s, fw, fd);
    chk("R3 maxcur0", lane(slot_maxcur, 0), 32'h2222_2222);
    bus_wr(12'h020, 32'h3333_3333, e, s, fw, fd);
    chk("R3 cap1", lane(slot_cap, 1), 32'h3333_3333);
    bus_wr(12'h028, 32'h4444_4444, e, s, fw, fd);
    chk("R3 maxcur1", lane(slot_maxcur, 1), 32'h4444_4444);
    chk("R3 cap0 held", lane(slot_cap, 0), 32'h1111_1111);
    bus_rd(12'h018, d, v, e, s, fa); chk("R3 read 0x018", d, 32'h2222_2222);
    bus_rd(12'h020, d, v, e, s, fa); chk("R3 read 0x020", d, 32'h3333_3333);
  endtask

  task automatic t_forward();
    bus_rd(12'h1A4, d, v, e, s, fa);
    chk("R4 sel slot0", 32'(s), 32'b01); chk("R4 offset slot0", 32'(fa), 32'hA4);
    chk("R4 data slot0", d, 32'hC0DE_00A4); chk("R4 no err", 32'(e), 32'd0);
    bus_rd(12'h230, d, v, e, s, fa);
    chk("R4 sel slot1", 32'(s), 32'b10); chk("R4 data slot1", d, 32'hC0DE_0130);
    bus_wr(12'h2FC, 32'h5A5A_0F0F, e, s, fw, fd);
    chk("R4 write sel", 32'(s), 32'b10); chk("R4 write strobe", 32'(fw), 32'd1);
    chk("R4 write data", fd, 32'h5A5A_0F0F);
  endtask

  task automatic t_outrange();
    bus_rd(12'h300, d, v, e, s, fa);
    chk("R5 read 0x300 data", d, 32'h0); chk("R5 read 0x300 err", 32'(e), 32'd1);
    chk("R5 read 0x300 sel", 32'(s), 32'd0);
    bus_rd(12'hFFC, d, v, e, s, fa);
    chk("R5 read 0xFFC data", d, 32'h0); chk("R5 read 0xFFC err", 32'(e), 32'd1);
    bus_wr(12'h400, 32'hFFFF_FFFF, e, s, fw, fd);
    chk("R5 write err", 32'(e), 32'd1); chk("R5 write sel", 32'(s), 32'd0);
    bus_rd(12'h000, d, v, e, s, fa); chk("R5 word 0 intact", d, 32'h0003_0000);
    chk("R5 err clears", 32'(e), 32'd0);
  endtask

  task automatic t_misalign();
    bus_wr(12'h042, 32'h0BAD_0BAD, e, s, fw, fd);
    chk("R6 write err", 32'(e), 32'd1);
    bus_rd(12'h040, d, v, e, s, fa); chk("R6 word 0x040 intact", d, 32'hDEAD_BEEF);
    bus_wr(12'h011, 32'h0BAD_0BAD, e, s, fw, fd);
    chk("R6 cap0 intact", lane(slot_cap, 0), 32'h1111_1111);
    bus_rd(12'h101, d, v, e, s, fa);
    chk("R6 read sel", 32'(s), 32'd0); chk("R6 read data", d, 32'h0);
    chk("R6 read err", 32'(e), 32'd1);
  endtask

  task automatic t_status_ro();
    bus_wr(12'h0FC, 32'hFFFF_FFFF, e, s, fw, fd);
    bus_rd(12'h0FC, d, v, e, s, fa); chk("R11 status after write", d, 32'h0);
    chk("R11 irq_out", 32'(irq_out), 32'd0);
  endtask

  task automatic set_lvl(input logic [NS-1:0] lv);
    @(negedge clk); slot_irq = lv;
    @(negedge clk);
  endtask

  task automatic t_irq();
    set_lvl(2'b01);
    chk("R7 rise slot0 irq", 32'(irq_out), 32'd1);
    bus_rd(12'h0FC, d, v, e, s, fa); chk("R7 status", d, 32'h1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R9 held high", 32'(irq_out), 32'd1);
    end
    set_lvl(2'b11);
    chk("R7 rise slot1 irq", 32'(irq_out), 32'd1);
    set_lvl(2'b10);
    chk("R8 fall slot0 with slot1 set", 32'(irq_out), 32'd0);
    bus_rd(12'h0FC, d, v, e, s, fa); chk("R8 status", d, 32'h2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R9 held low", 32'(irq_out), 32'd0);
    end
    set_lvl(2'b00);
    chk("R8 fall slot1", 32'(irq_out), 32'd0);
    bus_rd(12'h0FC, d, v, e, s, fa); chk("R8 status clear", d, 32'h0);
  endtask

  task automatic t_simul();
    set_lvl(2'b01);
    set_lvl(2'b10);
    chk("R10 slot1 rise wins", 32'(irq_out), 32'd1);
    set_lvl(2'b01);
    chk("R10 slot1 fall wins", 32'(irq_out), 32'd0);
    bus_rd(12'h0FC, d, v, e, s, fa); chk("R10 status", d, 32'h1);
    set_lvl(2'b10);
    chk("R10 swap again", 32'(irq_out), 32'd1);
    set_lvl(2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; slot_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_storage();
    t_alias();
    t_forward();
    t_outrange();
    t_misalign();
    t_status_ro();
    t_irq();
    t_simul();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule